// File: doc/BRIEF.md
# Paged SRAM Window Address Decoder

This block watches a slice of the system address bus and carves a 512-byte peripheral window out of the top of every 4 KB region where the ROM-bank enable is asserted. The window has no data path. Every effect comes from which 32-byte chunk of the window the bus touches. One chunk is a 32-byte viewport onto a 2 KB buffer SRAM. A 6-bit page register picks which of the 64 pages shows through that viewport. Touching other chunks clears the page register, advances it, or starts a timed pulse on one of two drive-control lines.

Address bits below A5 are not seen by the block and go straight to the SRAM. Address bits above A11 are not seen either. Each clock cycle counts as one bus cycle, and an access takes effect on the rising edge that ends it. Pulse lengths are given in microseconds and turned into clock counts from the clock-frequency parameter.

Top module: `pagewin_decoder`

## Requirements
- R1: The block is selected exactly when `rom_en_ni` is 0 and `addr_i[6:4]` (A11..A9) is 3'b111, whatever the value of `addr_i[3:0]`.
- R2: `rom_en_no` is 1 while the block is selected and equals `rom_en_ni` in every other cycle, combinationally.
- R3: `ram_en_no` is 0 only when the block is selected and `addr_i[3:0]` (A8..A5) is 4'h0. It is 1 otherwise.
- R4: `ram_addr_o` always shows the page register, and the page register is 0 after reset.
- R5: A selected access with `addr_i[3:0]` = 4'h1 adds one to the page register at the closing clock edge. 63 wraps to 0.
- R6: A selected access with `addr_i[3:0]` = 4'h5 sets the page register to 0 at the closing clock edge.
- R7: A selected access with `addr_i[3:0]` = 4'h3 raises `head_sel_o` from the next cycle for exactly HEAD_LEN cycles, where HEAD_LEN = max(1, CLK_HZ*HEAD_US/1e6).
- R8: A selected access with `addr_i[3:0]` = 4'h4 raises `drive_en_o` from the next cycle for exactly DRV_LEN cycles, where DRV_LEN = max(1, CLK_HZ*DRV_US/1e6).
- R9: A new trigger while a pulse is high restarts that pulse's full length, counted from the new trigger.
- R10: Unselected accesses, and selected accesses at offsets 4'h2 and 4'h6..4'hF, leave the page register and both pulse outputs unchanged.
- R11: Asserting `rst_ni` low clears the page register and ends both pulses at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock. One bus cycle per clock. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Address bits A11..A5 |
| rom_en_ni | input | 1 | ROM-bank enable from the system, active low |
| rom_en_no | output | 1 | ROM enable passed on to the ROM, active low |
| ram_en_no | output | 1 | Buffer SRAM enable, active low |
| ram_addr_o | output | 6 | Buffer SRAM address bits 10..5 (page register) |
| head_sel_o | output | 1 | Timed head-select pulse, active high |
| drive_en_o | output | 1 | Timed drive-enable pulse, active high |

## Verification
The critical overlap is a retrigger that lands on the same clock edge where a running pulse's counter would otherwise expire. Both the reload and the final decrement compete for that edge. The bench sweeps the retrigger distance from one cycle up to two cycles past the pulse length, so the case exactly on the expiry edge and the one-cycle gap just after it are both covered. Each sampled cycle is compared against the union of two arithmetic windows, one for the first pulse and one for the restarted pulse. The bench also runs page increments while a pulse is still counting, and checks that neither function disturbs the other.

// File: rtl/pagewin_pkg.sv
`timescale 1ns/1ps
package pagewin_pkg;
  localparam int unsigned ADDR_W = 7;   // A11..A5
  localparam int unsigned OFS_W  = 4;   // A8..A5
  localparam int unsigned SEL_W  = ADDR_W - OFS_W;
  localparam logic [SEL_W-1:0] SEL_MATCH = '1;

  typedef enum logic [OFS_W-1:0] {
    OFS_RAM  = 4'h0,
    OFS_INC  = 4'h1,
    OFS_HEAD = 4'h3,
    OFS_DRV  = 4'h4,
    OFS_CLR  = 4'h5
  } ofs_e;

  typedef struct packed {
    logic sel;
    logic ram;
    logic inc;
    logic clr;
    logic head;
    logic drv;
  } hit_t;

  function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
    longint unsigned n;
    n = (hz * us) / 64'd1_000_000;
    return (n == 0) ? 1 : int'(n);
  endfunction
endpackage

// File: rtl/pagewin_sel.sv
`timescale 1ns/1ps
module pagewin_sel
  import pagewin_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_en_ni,
  output hit_t              hit_o
);
  logic [SEL_W-1:0] sel_bits;
  logic [OFS_W-1:0] ofs;
  logic             sel;

  assign sel_bits = addr_i[ADDR_W-1 -: SEL_W];
  assign ofs      = addr_i[OFS_W-1:0];
  assign sel      = !rom_en_ni && (sel_bits == SEL_MATCH);

  always_comb begin
    hit_o      = '0;
    hit_o.sel  = sel;
    hit_o.ram  = sel && (ofs == OFS_RAM);
    hit_o.inc  = sel && (ofs == OFS_INC);
    hit_o.clr  = sel && (ofs == OFS_CLR);
    hit_o.head = sel && (ofs == OFS_HEAD);
    hit_o.drv  = sel && (ofs == OFS_DRV);
  end
endmodule

// File: rtl/pagewin_page.sv
`timescale 1ns/1ps
module pagewin_page #(
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              clr_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    page_q <= '0;
    else if (clr_i) page_q <= '0;
    else if (inc_i) page_q <= page_q + PAGE_W'(1); // natural wrap
  end

  assign page_o = page_q;
endmodule

// File: rtl/pagewin_pulse.sv
`timescale 1ns/1ps
module pagewin_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(LEN);   // restart on retrigger
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/pagewin_decoder.sv
`timescale 1ns/1ps
module pagewin_decoder
  import pagewin_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 64'd14_000_000,
  parameter longint unsigned HEAD_US = 64'd3000,
  parameter longint unsigned DRV_US  = 64'd500,
  parameter int unsigned     PAGE_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_en_ni,
  output logic              rom_en_no,
  output logic              ram_en_no,
  output logic [PAGE_W-1:0] ram_addr_o,
  output logic              head_sel_o,
  output logic              drive_en_o
);
  localparam int unsigned HEAD_LEN = us_to_cycles(CLK_HZ, HEAD_US);
  localparam int unsigned DRV_LEN  = us_to_cycles(CLK_HZ, DRV_US);
  localparam int unsigned N_PULSE  = 2;
  localparam int unsigned LENS [N_PULSE] = '{HEAD_LEN, DRV_LEN};

  hit_t               hit;
  logic [N_PULSE-1:0] trig;
  logic [N_PULSE-1:0] pulse;

  pagewin_sel u_sel (
    .addr_i    (addr_i),
    .rom_en_ni (rom_en_ni),
    .hit_o     (hit)
  );

  pagewin_page #(.PAGE_W(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (hit.inc),
    .clr_i  (hit.clr),
    .page_o (ram_addr_o)
  );

  assign trig = {hit.drv, hit.head};

  for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
    pagewin_pulse #(.LEN(LENS[g])) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig[g]),
      .pulse_o (pulse[g])
    );
  end

  assign head_sel_o = pulse[0];
  assign drive_en_o = pulse[1];
  assign rom_en_no  = hit.sel ? 1'b1 : rom_en_ni;
  assign ram_en_no  = !hit.ram;
endmodule

// File: rtl/pagewin_chk.sv
`timescale 1ns/1ps
module pagewin_chk #(
  parameter int unsigned PAGE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [6:0]        addr_i,
  input logic              rom_en_ni,
  input logic              rom_en_no,
  input logic              ram_en_no,
  input logic [PAGE_W-1:0] ram_addr_o,
  input logic              head_sel_o,
  input logic              drive_en_o
);
  logic in_win;
  assign in_win = !rom_en_ni && (addr_i[6:4] == 3'b111);

  AST_ROM_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> rom_en_no); // R2
  AST_ROM_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (rom_en_no == rom_en_ni)); // R2
  AST_RAM_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_en_no |-> (in_win && addr_i[3:0] == 4'h0)); // R3
  AST_PAGE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[3:0] == 4'h1) |=> (ram_addr_o == PAGE_W'($past(ram_addr_o) + 1'b1))); // R5
  AST_PAGE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[3:0] == 4'h5) |=> (ram_addr_o == '0)); // R6
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_win && (addr_i[3:0] == 4'h1 || addr_i[3:0] == 4'h5)) |=> $stable(ram_addr_o)); // R10
  AST_HEAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[3:0] == 4'h3) |=> head_sel_o); // R7
  AST_DRV_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[3:0] == 4'h4) |=> drive_en_o); // R8
  AST_HEAD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(head_sel_o) |-> $past(in_win && addr_i[3:0] == 4'h3)); // R10
  AST_DRV_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_en_o) |-> $past(in_win && addr_i[3:0] == 4'h4)); // R10
endmodule

bind pagewin_decoder pagewin_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rom_en_ni  (rom_en_ni),
  .rom_en_no  (rom_en_no),
  .ram_en_no  (ram_en_no),
  .ram_addr_o (ram_addr_o),
  .head_sel_o (head_sel_o),
  .drive_en_o (drive_en_o)
);

// File: tb/sim_pagewin_decoder.sv
`timescale 1ns/1ps
module sim_pagewin_decoder;
  localparam longint unsigned CLK_HZ  = 64'd1_000_000;
  localparam longint unsigned HEAD_US = 64'd12;
  localparam longint unsigned DRV_US  = 64'd5;
  localparam int HEAD_LEN = int'((CLK_HZ * HEAD_US) / 64'd1_000_000);
  localparam int DRV_LEN  = int'((CLK_HZ * DRV_US) / 64'd1_000_000);

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] addr_i = '0;
  logic       rom_en_ni = 1'b1;
  logic       rom_en_no, ram_en_no, head_sel_o, drive_en_o;
  logic [5:0] ram_addr_o;

  int checks = 0;
  int bad = 0;
  int exp_page = 0;

  always #2 clk_i = ~clk_i;

  pagewin_decoder #(.CLK_HZ(CLK_HZ), .HEAD_US(HEAD_US), .DRV_US(DRV_US)) u0 (
    .clk_i, .rst_ni, .addr_i, .rom_en_ni, .rom_en_no, .ram_en_no,
    .ram_addr_o, .head_sel_o, .drive_en_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    addr_i = '0;
    rom_en_ni = 1'b1;
  endtask

  task automatic hit(input logic [3:0] ofs);
    addr_i = {3'b111, ofs};
    rom_en_ni = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R4 R11 reset state
    chk("R4", int'(ram_addr_o), 0);
    chk("R11", int'(head_sel_o), 0);
    chk("R11", int'(drive_en_o), 0);
    chk("R2", int'(rom_en_no), 1);
    rst_ni = 1'b1;

    // R1 R2 R3 R5 R6 exhaustive address sweep, page tracked arithmetically
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 128; a++) begin
        @(negedge clk_i);
        chk("R4", int'(ram_addr_o), exp_page);
        addr_i = 7'(a);
        rom_en_ni = r[0];
        #1;
        begin
          bit s;
          s = (r == 0) && ((a >> 4) == 7);
          chk("R2", int'(rom_en_no), s ? 1 : r);
          chk("R3", int'(ram_en_no), (s && (a & 15) == 0) ? 0 : 1);
          if (s && (a & 15) == 1) exp_page = (exp_page + 1) % 64;
          if (s && (a & 15) == 5) exp_page = 0;
        end
      end
    end
    @(negedge clk_i);
    chk("R4", int'(ram_addr_o), exp_page);
    idle();

    // R5 full wrap, also while a head pulse runs
    @(negedge clk_i); hit(4'h5);
    @(negedge clk_i); hit(4'h3);
    for (int i = 1; i <= 64; i++) begin
      @(negedge clk_i);
      if (i > 1) chk("R5", int'(ram_addr_o), (i - 1) % 64);
      if (i <= HEAD_LEN) chk("R7", int'(head_sel_o), 1);
      hit(4'h1);
    end
    @(negedge clk_i);
    chk("R5", int'(ram_addr_o), 0);
    idle();
    repeat (HEAD_LEN + 2) @(negedge clk_i);

    // R10 undocumented offsets and unselected strobes
    @(negedge clk_i); hit(4'h1);
    @(negedge clk_i);
    chk("R5", int'(ram_addr_o), 1);
    for (int o = 0; o < 16; o++) begin
      if (o == 0 || o == 1 || o == 3 || o == 4 || o == 5) continue;
      hit(4'(o));
      @(negedge clk_i);
      chk("R10", int'(ram_addr_o), 1);
      chk("R10", int'(head_sel_o), 0);
      chk("R10", int'(drive_en_o), 0);
    end
    for (int o = 1; o < 6; o++) begin
      addr_i = {3'b111, 4'(o)};
      rom_en_ni = 1'b1;
      @(negedge clk_i);
      chk("R10", int'(ram_addr_o), 1);
      chk("R10", int'(head_sel_o), 0);
      chk("R10", int'(drive_en_o), 0);
    end
    addr_i = 7'b1100001; rom_en_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", int'(ram_addr_o), 1);
    idle();

    // R7 R8 single pulse length
    hit(4'h3);
    for (int k = 1; k <= HEAD_LEN + 3; k++) begin
      @(negedge clk_i);
      chk("R7", int'(head_sel_o), (k <= HEAD_LEN) ? 1 : 0);
      idle();
    end
    hit(4'h4);
    for (int k = 1; k <= DRV_LEN + 3; k++) begin
      @(negedge clk_i);
      chk("R8", int'(drive_en_o), (k <= DRV_LEN) ? 1 : 0);
      chk("R8", int'(head_sel_o), 0);
      idle();
    end

    // R9 retrigger sweep, including expiry-edge collision and one-cycle gap
    for (int d = 1; d <= HEAD_LEN + 2; d++) begin
      @(negedge clk_i); hit(4'h3);
      for (int k = 1; k <= d + HEAD_LEN + 2; k++) begin
        @(negedge clk_i);
        chk("R9", int'(head_sel_o),
            ((k <= HEAD_LEN) || (k >= d + 1 && k <= d + HEAD_LEN)) ? 1 : 0);
        if (k == d) hit(4'h3); else idle();
      end
    end
    for (int d = 1; d <= DRV_LEN + 2; d++) begin
      @(negedge clk_i); hit(4'h4);
      for (int k = 1; k <= d + DRV_LEN + 2; k++) begin
        @(negedge clk_i);
        chk("R9", int'(drive_en_o),
            ((k <= DRV_LEN) || (k >= d + 1 && k <= d + DRV_LEN)) ? 1 : 0);
        if (k == d) hit(4'h4); else idle();
      end
    end

    // R11 reset mid-pulse
    @(negedge clk_i); hit(4'h3);
    @(negedge clk_i); hit(4'h4);
    @(negedge clk_i); hit(4'h1);
    @(negedge clk_i); idle();
    chk("R7", int'(head_sel_o), 1);
    chk("R8", int'(drive_en_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R11", int'(head_sel_o), 0);
    chk("R11", int'(drive_en_o), 0);
    chk("R11", int'(ram_addr_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R11", int'(head_sel_o), 0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule